// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers 64 active-low interrupt request lines and presents them to a processor through a small 32-bit register port and one interrupt output. Each source owns one bit in one of two 32-bit words, the upper word or the lower word. The mask and pending registers both use this layout, and the source-to-bit assignment is a fixed scramble rather than a linear index. Software enables sources through the two mask words and acknowledges them by writing ones to the two pending words. It finds the winning source by reading a vector register whose top six bits hold the source number.

Most sources are internal and are always treated as active-low level requests. Sources 19 to 25 are external lines, which can be switched between level-low and falling-edge detection. Sources 48 to 63 are port lines, which detect either both edges (the default) or only falling edges. Source number 0 is reserved to mean "nothing active" and its input line is ignored. Each request line passes through one sampling register and one history register before the pending logic. The processor output and the vector are both registered.

Top module: `scram_icu`

## Requirements
- R1: Register offsets on `reg_addr`: 0 upper mask word, 1 lower mask word, 2 upper pending word, 3 lower pending word, 4 sense word, 5 vector. Other offsets read as zero and ignore writes.
- R2: Each source s in 1..63 owns exactly one bit. s=1..15 uses upper bit 16-s. s=16..18 uses lower bit 18-s. s=19..30 uses lower bit 33-s. s=31 uses lower bit 15. s=32..47 uses upper bit 63-s. s=48..63 uses lower bit s-32.
- R3: After reset, both mask words, both pending words, the sense word and the vector read as zero, and `cpu_irq` is low.
- R4: A mask bit of 1 lets its pending source drive `cpu_irq` and the vector. A mask bit of 0 blocks the source, but the source still shows in the pending words.
- R5: Writing a 1 to a pending bit clears it. Zero bits in the written value leave their pending bits unchanged.
- R6: In level mode, a pending bit is set every cycle its input is low. A clear written while the input stays low has no lasting effect.
- R7: External source s (19..25) has its sense bit at 33-s. A value of 0 selects level-low. A value of 1 selects falling-edge, where only a high-to-low transition sets pending.
- R8: Port source s (48..63) has its sense bit at s-32. A value of 0 selects both edges and a value of 1 selects falling edge only. In both cases pending is set only on a qualifying transition and stays cleared afterwards.
- R9: Sense bits other than 8..14 and 16..31 cannot be written and read as zero. Internal sources ignore the sense word.
- R10: The vector register returns, in bits 31:26, the lowest source number that is both pending and unmasked. It returns 0 when no source qualifies, and bits 25:0 always read zero.
- R11: `cpu_irq` is high exactly when at least one pending bit is also unmasked. It follows the pending and mask state with one register of delay.
- R12: The input of source 0 is ignored and never sets any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data appears on `reg_rdata` one cycle later |
| reg_rdata | output | 32 | Registered read data |
| src_n | input | 64 | Active-low interrupt request lines, index equals source number |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench raises each of the 63 usable sources in turn and checks that exactly the one expected bit appears in exactly one word. A design with a wrong row in the scramble would either light the wrong bit or collide with a neighbour, such as sources 18 and 31. It then tries to acknowledge a level source while its line is still held low, expecting the bit to come straight back. It also acknowledges a falling-edge source under the same held-low condition, expecting the bit to stay clear. A design that treats every source alike fails one of the two. Port lines are driven through both edges under both sense settings to catch inverted sense polarity. A mixed set of requests, retired one by one, confirms that the vector always names the lowest active number rather than the highest or the first by word position.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int NUM_SRC = 64;
  localparam int WORD_W  = 32;
  localparam int VEC_W   = 6;

  localparam int ADR_MASK_HI = 0;
  localparam int ADR_MASK_LO = 1;
  localparam int ADR_PEND_HI = 2;
  localparam int ADR_PEND_LO = 3;
  localparam int ADR_SENSE   = 4;
  localparam int ADR_VEC     = 5;

  localparam logic [WORD_W-1:0] SENSE_WMASK = 32'hFFFF_7F00;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_INT  = 2'd1,
    CLS_EXT  = 2'd2,
    CLS_PORT = 2'd3
  } src_cls_t;

  // upper (1) or lower (0) word holding source s
  function automatic logic src_in_hi(input int s);
    return (s < 16) || ((s >= 32) && (s < 48));
  endfunction

  // bit index inside its word
  function automatic int src_bit(input int s);
    if (s == 0)      return 0;
    else if (s < 16) return 16 - s;
    else if (s < 19) return 18 - s;
    else if (s < 31) return 33 - s;
    else if (s == 31) return 15;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction

  function automatic src_cls_t src_class(input int s);
    if (s == 0)                  return CLS_NONE;
    else if (s >= 19 && s <= 25) return CLS_EXT;
    else if (s >= 48)            return CLS_PORT;
    else                         return CLS_INT;
  endfunction

  function automatic int sense_pos(input int s);
    if (s >= 19 && s <= 25) return 33 - s;
    else if (s >= 48)       return s - 32;
    else                    return 0;
  endfunction
endpackage

// File: rtl/icu_edge_sampler.sv
module icu_edge_sampler #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] fall_ev,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] low_lvl
);
  logic [N-1:0] smp_q;
  logic [N-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '1;
      hist_q <= '1;
    end else begin
      smp_q  <= line_n;
      hist_q <= smp_q;
    end
  end

  assign fall_ev = hist_q & ~smp_q;
  assign rise_ev = ~hist_q & smp_q;
  assign low_lvl = ~smp_q;
endmodule

// File: rtl/icu_pending_bank.sv
module icu_pending_bank import icu_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  fall_ev,
  input  logic [NUM_SRC-1:0]  rise_ev,
  input  logic [NUM_SRC-1:0]  low_lvl,
  input  logic [WORD_W-1:0]   sense,
  input  logic [WORD_W-1:0]   mask_hi,
  input  logic [WORD_W-1:0]   mask_lo,
  input  logic [WORD_W-1:0]   clr_hi,
  input  logic [WORD_W-1:0]   clr_lo,
  output logic [WORD_W-1:0]   pend_hi,
  output logic [WORD_W-1:0]   pend_lo,
  output logic [NUM_SRC-1:0]  active
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] clr_v;
  logic [NUM_SRC-1:0] lvl_v;
  logic [NUM_SRC-1:0] msk_v;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic     HI  = src_in_hi(s);
    localparam int       BI  = src_bit(s);
    localparam src_cls_t CL  = src_class(s);
    localparam int       SP  = sense_pos(s);

    assign clr_v[s] = HI ? clr_hi[BI]  : clr_lo[BI];
    assign msk_v[s] = HI ? mask_hi[BI] : mask_lo[BI];

    if (CL == CLS_NONE) begin : g_rsvd
      assign lvl_v[s] = 1'b0;
      assign set_v[s] = 1'b0;
    end else if (CL == CLS_INT) begin : g_int
      assign lvl_v[s] = 1'b1;
      assign set_v[s] = low_lvl[s];
    end else if (CL == CLS_EXT) begin : g_ext
      assign lvl_v[s] = ~sense[SP];
      assign set_v[s] = sense[SP] ? fall_ev[s] : low_lvl[s];
    end else begin : g_port
      assign lvl_v[s] = 1'b0;
      assign set_v[s] = sense[SP] ? fall_ev[s] : (fall_ev[s] | rise_ev[s]);
    end

    always_ff @(posedge clk) begin
      if (rst) pend[s] <= 1'b0;
      else     pend[s] <= set_v[s] | (pend[s] & ~clr_v[s]);
    end
  end

  assign active = pend & msk_v;

  always_comb begin
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (src_in_hi(s)) pend_hi[src_bit(s)] = pend[s];
      else              pend_lo[src_bit(s)] = pend[s];
    end
  end

  AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (rst)
    (($past(lvl_v & low_lvl) & ~pend) == '0)); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (($past(clr_v & ~set_v) & pend) == '0)); // R5

  AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pend[0]); // R12
endmodule

// File: rtl/icu_lowest_first.sv
module icu_lowest_first #(
  parameter int N   = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/scram_icu.sv
module scram_icu import icu_pkg::*; #(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic                reg_rd,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0]  src_n,
  output logic                cpu_irq
);
  localparam int PAD_W = WORD_W - VEC_W;

  logic [WORD_W-1:0]  mask_hi, mask_lo, sense_q;
  logic [WORD_W-1:0]  pend_hi, pend_lo;
  logic [WORD_W-1:0]  clr_hi, clr_lo;
  logic [NUM_SRC-1:0] fall_ev, rise_ev, low_lvl, active;
  logic [VEC_W-1:0]   win_idx, vec_q;

  logic wr_mhi, wr_mlo, wr_phi, wr_plo, wr_sns;
  assign wr_mhi = reg_wr && (reg_addr == ADDR_W'(ADR_MASK_HI));
  assign wr_mlo = reg_wr && (reg_addr == ADDR_W'(ADR_MASK_LO));
  assign wr_phi = reg_wr && (reg_addr == ADDR_W'(ADR_PEND_HI));
  assign wr_plo = reg_wr && (reg_addr == ADDR_W'(ADR_PEND_LO));
  assign wr_sns = reg_wr && (reg_addr == ADDR_W'(ADR_SENSE));

  assign clr_hi = wr_phi ? reg_wdata : '0;
  assign clr_lo = wr_plo ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi <= '0;
      mask_lo <= '0;
      sense_q <= '0;
    end else begin
      if (wr_mhi) mask_hi <= reg_wdata;
      if (wr_mlo) mask_lo <= reg_wdata;
      if (wr_sns) sense_q <= reg_wdata & SENSE_WMASK;
    end
  end

  icu_edge_sampler #(.N(NUM_SRC)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .line_n  (src_n),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev),
    .low_lvl (low_lvl)
  );

  icu_pending_bank u_pend (
    .clk     (clk),
    .rst     (rst),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev),
    .low_lvl (low_lvl),
    .sense   (sense_q),
    .mask_hi (mask_hi),
    .mask_lo (mask_lo),
    .clr_hi  (clr_hi),
    .clr_lo  (clr_lo),
    .pend_hi (pend_hi),
    .pend_lo (pend_lo),
    .active  (active)
  );

  icu_lowest_first #(.N(NUM_SRC), .IDX_W(VEC_W)) u_prio (
    .req (active),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      cpu_irq <= 1'b0;
    end else begin
      vec_q   <= win_idx;
      cpu_irq <= |active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(ADR_MASK_HI): reg_rdata <= mask_hi;
        ADDR_W'(ADR_MASK_LO): reg_rdata <= mask_lo;
        ADDR_W'(ADR_PEND_HI): reg_rdata <= pend_hi;
        ADDR_W'(ADR_PEND_LO): reg_rdata <= pend_lo;
        ADDR_W'(ADR_SENSE):   reg_rdata <= sense_q;
        ADDR_W'(ADR_VEC):     reg_rdata <= {vec_q, {PAD_W{1'b0}}};
        default:              reg_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ($past(mask_hi | mask_lo) != '0)); // R4

  AST_VEC_IFF_IRQ: assert property (@(posedge clk) disable iff (rst)
    ((vec_q != '0) == cpu_irq)); // R10

  AST_SENSE_HOLES: assert property (@(posedge clk) disable iff (rst)
    ((sense_q & ~SENSE_WMASK) == '0)); // R9
endmodule

// File: tb/test_scram_icu.sv
module test_scram_icu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [63:0] src_n = '1;
  logic        cpu_irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  scram_icu i_scram_icu (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .src_n(src_n), .cpu_irq(cpu_irq)
  );

  function automatic bit exp_hi(input int s);
    case (s) inside
      [1:15], [32:47]: return 1'b1;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic int exp_bit(input int s);
    case (s) inside
      [1:15]:  return 16 - s;
      [16:18]: return 18 - s;
      [19:30]: return 33 - s;
      31:      return 15;
      [32:47]: return 63 - s;
      default: return s - 32;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic word_of(input int s, output int pa, output int ma, output logic [31:0] b);
    pa = exp_hi(s) ? 2 : 3;
    ma = exp_hi(s) ? 0 : 1;
    b = 32'h1 << exp_bit(s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d, b, other;
    int pa, ma, oa;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R3 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, d); chk("R3 reset reg", d, 32'h0);
    end
    chk("R3 reset irq", {31'b0, cpu_irq}, 32'h0);
    rd(7, d); chk("R1 unused offset", d, 32'h0);

    // R12 source 0 ignored
    src_n[0] = 1'b0; idle(4);
    rd(2, d); chk("R12 src0 hi", d, 32'h0);
    rd(3, d); chk("R12 src0 lo", d, 32'h0);
    src_n[0] = 1'b1; idle(2);

    // R2 R4 R5 R6 R8 R10 R11: sweep every source with default sense
    for (int s = 1; s < 64; s++) begin
      word_of(s, pa, ma, b);
      oa = (pa == 2) ? 3 : 2;
      src_n[s] = 1'b0; idle(4);
      rd(pa, d); chk($sformatf("R2 src%0d bit", s), d, b);
      rd(oa, other); chk($sformatf("R2 src%0d other word", s), other, 32'h0);
      chk($sformatf("R4 src%0d masked irq", s), {31'b0, cpu_irq}, 32'h0);
      rd(5, d); chk($sformatf("R4 src%0d masked vec", s), d, 32'h0);
      wr(ma, b); idle(3);
      chk($sformatf("R11 src%0d irq", s), {31'b0, cpu_irq}, 32'h1);
      rd(5, d); chk($sformatf("R10 src%0d vec", s), d, 32'(s) << 26);
      wr(pa, b); idle(3);
      rd(pa, d);
      if (s >= 48) begin
        chk($sformatf("R8 src%0d clear held low", s), d, 32'h0);
        src_n[s] = 1'b1; idle(4);
        rd(pa, d); chk($sformatf("R8 src%0d rising both-edge", s), d, b);
        wr(pa, b); idle(3);
      end else begin
        chk($sformatf("R6 src%0d level re-sets", s), d, b);
        src_n[s] = 1'b1; idle(3);
        wr(pa, b); idle(3);
      end
      rd(pa, d); chk($sformatf("R5 src%0d cleared", s), d, 32'h0);
      chk($sformatf("R11 src%0d irq low", s), {31'b0, cpu_irq}, 32'h0);
      wr(ma, 32'h0);
    end

    // R9 sense holes
    wr(4, 32'hFFFF_FFFF);
    rd(4, d); chk("R9 sense writable bits", d, 32'hFFFF_7F00);
    wr(4, 32'h0);
    // R9 internal source ignores sense bit 0 region
    wr(4, 32'h0000_00FF);
    src_n[40] = 1'b0; idle(4);
    wr(2, 32'h1 << exp_bit(40)); idle(3);
    rd(2, d); chk("R9 internal stays level", d, 32'h1 << exp_bit(40));
    src_n[40] = 1'b1; idle(3); wr(2, 32'hFFFF_FFFF); wr(4, 32'h0);

    // R7 external falling edge: source 20, sense bit 13
    wr(4, 32'h1 << 13);
    src_n[20] = 1'b0; idle(4);
    rd(3, d); chk("R7 ext fall sets", d, 32'h1 << 13);
    wr(3, 32'h1 << 13); idle(3);
    rd(3, d); chk("R7 ext fall held low stays clear", d, 32'h0);
    src_n[20] = 1'b1; idle(4);
    rd(3, d); chk("R7 ext rise ignored", d, 32'h0);
    wr(4, 32'h0);

    // R8 port falling only: source 50, sense bit 18
    wr(4, 32'h1 << 18);
    src_n[50] = 1'b0; idle(4);
    rd(3, d); chk("R8 port fall sets", d, 32'h1 << 18);
    wr(3, 32'h1 << 18); idle(3);
    src_n[50] = 1'b1; idle(4);
    rd(3, d); chk("R8 port rise ignored", d, 32'h0);
    wr(4, 32'h0);

    // R10 priority: sources 5, 40 level; 63 edge
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    src_n[63] = 1'b0; src_n[40] = 1'b0; src_n[5] = 1'b0; idle(4);
    rd(5, d); chk("R10 lowest wins 5", d, 32'd5 << 26);
    src_n[5] = 1'b1; idle(3); wr(2, 32'h1 << 11); idle(3);
    rd(5, d); chk("R10 next is 40", d, 32'd40 << 26);
    src_n[40] = 1'b1; idle(3); wr(2, 32'h1 << 23); idle(3);
    rd(5, d); chk("R10 next is 63", d, 32'd63 << 26);
    wr(3, 32'h8000_0000); idle(3);
    rd(5, d); chk("R10 none left", d, 32'h0);
    chk("R11 irq drops", {31'b0, cpu_irq}, 32'h0);
    src_n[63] = 1'b1; idle(4);
    wr(3, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    // R5 zero bits leave others: pend 2 and 3 (upper bits 14,13)
    src_n[2] = 1'b0; src_n[3] = 1'b0; idle(4);
    src_n[2] = 1'b1; src_n[3] = 1'b1; idle(3);
    wr(2, 32'h1 << 14); idle(2);
    rd(2, d); chk("R5 partial clear", d, 32'h1 << 13);
    wr(2, 32'hFFFF_FFFF); idle(2);
    rd(2, d); chk("R5 all-ones clear", d, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule